// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block moves outgoing packets from memory to a byte stream by following a chain of descriptors. Software programs the address of the first descriptor, then writes the DMA enable bit while the MAC transmit enable is high. The engine reads each descriptor's three words and streams that packet's bytes over a valid/ready interface. It then gives the descriptor back to software by setting the top bit of its size word, and moves on to the next descriptor in the chain.

The chain ends at the first descriptor whose ownership bit shows it as empty. At that point the engine raises a sticky underrun flag and clears its own enable bit. A per-chain loopback selection sends the bytes to a local receive-side port instead of the transmit port. Each retired packet bumps an 8-bit packet counter and sets a sticky packet-sent flag. Framing, checksum and inter-frame spacing are handled elsewhere.

Top module: `txdma_engine`

## Requirements
- R1: After reset, dmaEnable, underrun, pktSent and pktCount are all zero, and txValid, lbValid and memReq are low.
- R2: A chain starts only when dmaEnWr carries dmaEnWrData=1 while the engine is idle and txEnCfg is high. If txEnCfg is low, the written bit is stored and reads back on dmaEnable, but no memory access is made.
- R3: A descriptor is three consecutive 32-bit words at byte offsets 0, 4 and 8: buffer byte address, size word, next-descriptor pointer. The buffer byte at address a is taken from word a with bits 1:0 cleared, bits 8*a[1:0]+7 down to 8*a[1:0] (little-endian). Bits 1:0 of a value written through descAddrWr are forced to zero, and so are bits 1:0 of a fetched next pointer.
- R4: A size word with bit 31 set marks an empty descriptor. The engine sends nothing for it, sets underrun, clears dmaEnable and returns to idle.
- R5: The packet length is size word bits 10:0. The bytes go out in ascending address order, with the last flag only on the final byte. A length of zero sends no bytes, but the descriptor is still retired.
- R6: While an offered byte is not accepted, valid stays high and the data and last flag stay stable.
- R7: Only after the last byte is accepted is the size word rewritten at descriptor offset 4, with bit 31 set and all other bits unchanged. The other two descriptor words are never written.
- R8: Each retired descriptor adds one to pktCount (modulo 256) and sets pktSent. Processing then continues at the next pointer.
- R9: When loopbackCfg is high at chain start, the bytes of the whole chain go to the lb port and txValid stays low. Otherwise they go to the tx port and lbValid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descAddrWr | input | 1 | Write strobe for the first-descriptor address |
| descAddrWrData | input | AW | First-descriptor byte address |
| dmaEnWr | input | 1 | Write strobe for the DMA enable bit |
| dmaEnWrData | input | 1 | Value written to the DMA enable bit |
| txEnCfg | input | 1 | MAC transmit enable |
| loopbackCfg | input | 1 | Route the chain to the loopback port |
| memReq | output | 1 | Memory access request, held until memAck |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access completes this cycle |
| txValid | output | 1 | Transmit byte valid |
| txData | output | 8 | Transmit byte |
| txLast | output | 1 | Final byte of the packet |
| txReady | input | 1 | Transmit sink accepts |
| lbValid | output | 1 | Loopback byte valid |
| lbData | output | 8 | Loopback byte |
| lbLast | output | 1 | Final byte on the loopback port |
| lbReady | input | 1 | Loopback sink accepts |
| dmaEnable | output | 1 | DMA enable bit |
| underrun | output | 1 | Sticky end-of-chain flag |
| pktSent | output | 1 | Sticky packet-retired flag |
| pktCount | output | CNT_W | Retired packet count |

## Verification
The main chain walks sixteen descriptors whose lengths sweep 0 through 12 and whose buffer offsets sweep all four byte lanes. This separates errors in lane selection, length masking, last-flag placement and zero-length handling. The same chain is repeated with periodic stalls on memory acknowledge and sink ready, which tests the hold rules and makes sure writeback waits for acceptance. Extra runs cover an unaligned start address, a chain that is empty from the first descriptor, a loopback chain and an enable write with the MAC transmit enable low. Together these separate the stop, routing and start-gating behaviour.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_BUF,
    ST_RD_SIZE,
    ST_RD_NEXT,
    ST_FETCH,
    ST_SEND,
    ST_WB
  } txdmaState_t;

  typedef enum logic [1:0] {
    SEL_BUFPTR,
    SEL_SIZE,
    SEL_NEXT,
    SEL_DATA
  } memSel_t;

  typedef struct packed {
    logic    idle;
    logic    start;
    logic    loadBuf;
    logic    loadSize;
    logic    loadNext;
    logic    latchByte;
    logic    advByte;
    logic    wbDone;
    logic    finish;
    memSel_t memSel;
  } ctrlStrobe_t;

  localparam logic [31:0] OWN_EMPTY = 32'h8000_0000;

endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaEnWr,
  input  logic        dmaEnWrData,
  input  logic        txEnCfg,
  input  logic        memAck,
  input  logic        descEmpty,
  input  logic        lenZero,
  input  logic        lastByte,
  input  logic        outReady,
  output logic        memReq,
  output logic        memWe,
  output logic        outValid,
  output ctrlStrobe_t strobe
);

  txdmaState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    outValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobe.idle = 1'b1;
        if (dmaEnWr && dmaEnWrData && txEnCfg) begin
          strobe.start = 1'b1;
          nextState    = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        memReq        = 1'b1;
        strobe.memSel = SEL_BUFPTR;
        if (memAck) begin
          strobe.loadBuf = 1'b1;
          nextState      = ST_RD_SIZE;
        end
      end
      ST_RD_SIZE: begin
        memReq        = 1'b1;
        strobe.memSel = SEL_SIZE;
        if (memAck) begin
          if (descEmpty) begin
            strobe.finish = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            strobe.loadSize = 1'b1;
            nextState       = ST_RD_NEXT;
          end
        end
      end
      ST_RD_NEXT: begin
        memReq        = 1'b1;
        strobe.memSel = SEL_NEXT;
        if (memAck) begin
          strobe.loadNext = 1'b1;
          nextState       = lenZero ? ST_WB : ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq        = 1'b1;
        strobe.memSel = SEL_DATA;
        if (memAck) begin
          strobe.latchByte = 1'b1;
          nextState        = ST_SEND;
        end
      end
      ST_SEND: begin
        outValid = 1'b1;
        if (outReady) begin
          if (lastByte) nextState = ST_WB;
          else begin
            strobe.advByte = 1'b1;
            nextState      = ST_FETCH;
          end
        end
      end
      ST_WB: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.memSel = SEL_SIZE;
        if (memAck) begin
          strobe.wbDone = 1'b1;
          nextState     = ST_RD_BUF;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/txdma_datapath.sv
module txdma_datapath
  import txdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              descAddrWr,
  input  logic [AW-1:0]     descAddrWrData,
  input  logic              dmaEnWr,
  input  logic              dmaEnWrData,
  input  logic              loopbackCfg,
  input  logic [31:0]       memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [31:0]       memWdata,
  output logic [7:0]        byteData,
  output logic              lbSel,
  output logic              descEmpty,
  output logic              lenZero,
  output logic              lastByte,
  output logic              dmaEnable,
  output logic              underrun,
  output logic              pktSent,
  output logic [CNT_W-1:0]  pktCount
);

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0]    descPtr, bufPtr, nextPtr, bufByte;
  logic [31:0]      sizeWord;
  logic [LEN_W-1:0] byteIdx, pktLen;
  logic [7:0]       laneByte;

  assign pktLen    = sizeWord[LEN_W-1:0];
  assign bufByte   = bufPtr + AW'(byteIdx);
  assign laneByte  = memRdata[{bufByte[1:0], 3'b000} +: 8];
  assign descEmpty = memRdata[31];
  assign lenZero   = (pktLen == '0);
  assign lastByte  = (byteIdx == pktLen - LEN_W'(1));
  assign memWdata  = sizeWord | OWN_EMPTY;

  always_comb begin
    unique case (strobe.memSel)
      SEL_BUFPTR: memAddr = descPtr;
      SEL_SIZE:   memAddr = descPtr + AW'(4);
      SEL_NEXT:   memAddr = descPtr + AW'(8);
      default:    memAddr = bufByte & ALIGN_MASK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr   <= '0;
      bufPtr    <= '0;
      nextPtr   <= '0;
      sizeWord  <= '0;
      byteIdx   <= '0;
      byteData  <= '0;
      lbSel     <= 1'b0;
      dmaEnable <= 1'b0;
      underrun  <= 1'b0;
      pktSent   <= 1'b0;
      pktCount  <= '0;
    end else begin
      if (strobe.idle && descAddrWr) descPtr <= descAddrWrData & ALIGN_MASK;
      if (strobe.idle && dmaEnWr)    dmaEnable <= dmaEnWrData;
      if (strobe.start)     lbSel    <= loopbackCfg;
      if (strobe.loadBuf)   bufPtr   <= AW'(memRdata);
      if (strobe.loadSize) begin
        sizeWord <= memRdata;
        byteIdx  <= '0;
      end
      if (strobe.loadNext)  nextPtr  <= AW'(memRdata) & ALIGN_MASK;
      if (strobe.latchByte) byteData <= laneByte;
      if (strobe.advByte)   byteIdx  <= byteIdx + LEN_W'(1);
      if (strobe.wbDone) begin
        descPtr  <= nextPtr;
        pktCount <= pktCount + CNT_W'(1);
        pktSent  <= 1'b1;
      end
      if (strobe.finish) begin
        underrun  <= 1'b1;
        dmaEnable <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descAddrWr,
  input  logic [AW-1:0]    descAddrWrData,
  input  logic             dmaEnWr,
  input  logic             dmaEnWrData,
  input  logic             txEnCfg,
  input  logic             loopbackCfg,
  output logic             memReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  input  logic             memAck,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast,
  input  logic             txReady,
  output logic             lbValid,
  output logic [7:0]       lbData,
  output logic             lbLast,
  input  logic             lbReady,
  output logic             dmaEnable,
  output logic             underrun,
  output logic             pktSent,
  output logic [CNT_W-1:0] pktCount
);

  ctrlStrobe_t strobe;
  logic        outValid, outReady, lbSel;
  logic        descEmpty, lenZero, lastByte;
  logic [7:0]  byteData;

  txdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .dmaEnWr(dmaEnWr), .dmaEnWrData(dmaEnWrData), .txEnCfg(txEnCfg),
    .memAck(memAck), .descEmpty(descEmpty), .lenZero(lenZero),
    .lastByte(lastByte), .outReady(outReady),
    .memReq(memReq), .memWe(memWe), .outValid(outValid), .strobe(strobe)
  );

  txdma_datapath #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .descAddrWr(descAddrWr), .descAddrWrData(descAddrWrData),
    .dmaEnWr(dmaEnWr), .dmaEnWrData(dmaEnWrData), .loopbackCfg(loopbackCfg),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .byteData(byteData), .lbSel(lbSel), .descEmpty(descEmpty),
    .lenZero(lenZero), .lastByte(lastByte), .dmaEnable(dmaEnable),
    .underrun(underrun), .pktSent(pktSent), .pktCount(pktCount)
  );

  assign outReady = lbSel ? lbReady : txReady;
  assign txValid  = outValid & ~lbSel;
  assign lbValid  = outValid &  lbSel;
  assign txData   = byteData;
  assign lbData   = byteData;
  assign txLast   = outValid & ~lbSel & lastByte;
  assign lbLast   = outValid &  lbSel & lastByte;

endmodule

// File: rtl/txdma_checker.sv
module txdma_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             memWe,
  input logic             memAck,
  input logic [31:0]      memWdata,
  input logic             txValid,
  input logic [7:0]       txData,
  input logic             txLast,
  input logic             txReady,
  input logic             lbValid,
  input logic [7:0]       lbData,
  input logic             lbLast,
  input logic             lbReady,
  input logic             dmaEnable,
  input logic             underrun,
  input logic             pktSent,
  input logic [CNT_W-1:0] pktCount
);

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));

  assert_lb_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    lbValid && !lbReady |=> lbValid && $stable(lbData) && $stable(lbLast));

  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && lbValid));

  assert_wb_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[31]);

  assert_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> !dmaEnable && !memReq);

  assert_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pktCount != $past(pktCount)) |-> pktSent && $past(memReq && memWe && memAck));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid || lbValid) |-> !memReq);

endmodule

bind txdma_engine txdma_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memWdata(memWdata), .txValid(txValid), .txData(txData), .txLast(txLast),
  .txReady(txReady), .lbValid(lbValid), .lbData(lbData), .lbLast(lbLast),
  .lbReady(lbReady), .dmaEnable(dmaEnable), .underrun(underrun),
  .pktSent(pktSent), .pktCount(pktCount)
);

// File: tb/txdma_engine_tb.sv
module txdma_engine_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          descAddrWr = 0, dmaEnWr = 0, dmaEnWrData = 0;
  logic [AW-1:0] descAddrWrData = '0;
  logic          txEnCfg = 0, loopbackCfg = 0;
  logic          memReq, memWe, memAck;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata, memRdata;
  logic          txValid, txLast, lbValid, lbLast;
  logic [7:0]    txData, lbData, pktCount;
  logic          txReady = 1, lbReady = 1, ackOk = 1;
  logic          dmaEnable, underrun, pktSent;

  txdma_engine dut_i (.*);

  logic [31:0] mem [0:255];
  assign memRdata = mem[memAddr[9:2]];
  assign memAck   = memReq & ackOk;

  int stallMode = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    txReady <= (stallMode == 0) ? 1'b1 : (cyc % 3 != 0);
    lbReady <= (stallMode == 0) ? 1'b1 : (cyc % 5 != 2);
    ackOk   <= (stallMode == 0) ? 1'b1 : (cyc % 4 != 1);
  end

  logic [7:0] txGot [0:1023];
  logic       txGotLast [0:1023];
  logic [7:0] lbGot [0:1023];
  logic       lbGotLast [0:1023];
  int txN = 0, lbN = 0, reqSeen = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      txN <= 0; lbN <= 0; reqSeen <= 0;
    end else begin
      if (memReq && memAck && memWe) mem[memAddr[9:2]] <= memWdata;
      if (memReq) reqSeen <= reqSeen + 1;
      if (txValid && txReady) begin
        txGot[txN] <= txData; txGotLast[txN] <= txLast; txN <= txN + 1;
      end
      if (lbValid && lbReady) begin
        lbGot[lbN] <= lbData; lbGotLast[lbN] <= lbLast; lbN <= lbN + 1;
      end
    end
  end

  int nChecks = 0, nFail = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic int lenOf(input int i);  return i % 13; endfunction
  function automatic int bufOf(input int i);  return 32'h200 + 20 * i + (i % 4); endfunction
  function automatic logic [31:0] sizeOf(input int i);
    return 32'(lenOf(i)) | ((i % 2 == 1) ? 32'h0010_0000 : 32'h0);
  endfunction

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic buildMem(input int n);
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    for (int w = 0; w < 128; w++) mem[w] = 32'h0;
    for (int i = 0; i < n; i++) begin
      mem[4*i]   = 32'(bufOf(i));
      mem[4*i+1] = sizeOf(i);
      mem[4*i+2] = 32'(16 * (i + 1));
    end
    mem[4*n]   = 32'h300;
    mem[4*n+1] = 32'h8000_0005;
    mem[4*n+2] = 32'h0;
  endtask

  task automatic startChain(input logic [31:0] base);
    descAddrWr = 1; descAddrWrData = base;
    @(negedge clk);
    descAddrWr = 0;
    dmaEnWr = 1; dmaEnWrData = 1;
    @(negedge clk);
    dmaEnWr = 0; dmaEnWrData = 0;
  endtask

  task automatic waitDone();
    int t = 0;
    while (!underrun && t < 20000) begin @(negedge clk); t++; end
    if (!underrun) check(0, "watchdog", t, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic runChain(input int n, input bit lb, input int mode, input logic [31:0] base, input string tag);
    int k;
    stallMode = mode;
    buildMem(n);
    doReset();
    txEnCfg = 1; loopbackCfg = lb;
    startChain(base);
    loopbackCfg = ~lb;   // later changes must not matter (R9)
    waitDone();
    k = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < lenOf(i); j++) begin
        if (lb) begin
          check(lbGot[k] == pat(bufOf(i) + j), {"R3 R5 lane data ", tag}, lbGot[k], pat(bufOf(i) + j));
          check(lbGotLast[k] == (j == lenOf(i) - 1), {"R5 last ", tag}, lbGotLast[k], j == lenOf(i) - 1);
        end else begin
          check(txGot[k] == pat(bufOf(i) + j), {"R3 R5 lane data ", tag}, txGot[k], pat(bufOf(i) + j));
          check(txGotLast[k] == (j == lenOf(i) - 1), {"R5 last ", tag}, txGotLast[k], j == lenOf(i) - 1);
        end
        k++;
      end
    check((lb ? lbN : txN) == k, {"R5 byte count ", tag}, lb ? lbN : txN, k);
    check((lb ? txN : lbN) == 0, {"R9 other port idle ", tag}, lb ? txN : lbN, 0);
    for (int i = 0; i < n; i++) begin
      check(mem[4*i+1] == (sizeOf(i) | 32'h8000_0000), {"R7 writeback ", tag}, mem[4*i+1], sizeOf(i) | 32'h8000_0000);
      check(mem[4*i] == 32'(bufOf(i)) && mem[4*i+2] == 32'(16*(i+1)), {"R7 other words ", tag}, mem[4*i], bufOf(i));
    end
    check(mem[4*n+1] == 32'h8000_0005, {"R4 empty desc untouched ", tag}, mem[4*n+1], 32'h8000_0005);
    check(pktCount == 8'(n), {"R8 count ", tag}, pktCount, n);
    check(pktSent == (n > 0), {"R8 sent ", tag}, pktSent, n > 0);
    check(underrun == 1, {"R4 underrun ", tag}, underrun, 1);
    check(dmaEnable == 0, {"R4 enable cleared ", tag}, dmaEnable, 0);
  endtask

  initial begin
    rstN = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(dmaEnable == 0 && underrun == 0 && pktSent == 0, "R1 flags", {dmaEnable, underrun, pktSent}, 0);
    check(pktCount == 0, "R1 count", pktCount, 0);
    check(!txValid && !lbValid && !memReq, "R1 idle outputs", {txValid, lbValid, memReq}, 0);

    // R2 enable with MAC transmit enable low
    buildMem(3);
    doReset();
    txEnCfg = 0;
    startChain(32'h0);
    repeat (50) @(negedge clk);
    check(reqSeen == 0, "R2 no access", reqSeen, 0);
    check(dmaEnable == 1, "R2 bit stored", dmaEnable, 1);
    check(pktCount == 0 && txN == 0, "R2 nothing sent", pktCount, 0);

    runChain(16, 0, 0, 32'h0, "tx free");
    runChain(16, 0, 1, 32'h0, "tx stall");
    runChain(5, 1, 1, 32'h0, "loopback");
    runChain(4, 0, 0, 32'h2, "unaligned base R3");
    runChain(0, 0, 1, 32'h0, "empty first");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #800000;
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule